// File: doc/BRIEF.md
# Pipeline Redirect and Flush Controller

This block is the wrong-path cleanup logic of a five-stage in-order pipeline. Fetch always runs ahead sequentially, so every branch is treated as not taken until it is resolved. When a branch resolved in the memory stage turns out to be taken, the three younger instructions already fetched are wrong-path work. The block then raises kill strobes for the fetch, decode and execute stage registers in the same cycle and steers the program counter to the branch target.

The same unit handles an arithmetic overflow raised by the instruction in the execute stage. It blocks that instruction's register write, kills the two younger instructions behind it, sends fetch to a fixed handler vector and records the address of the instruction after the faulting one in a trap-PC register. The decode-stage kill shares the bubble path used by the hazard unit's stall request. When both a taken branch and an overflow are reported in one cycle, the exception takes the redirect.

All flush and next-PC outputs are combinational from the same-cycle inputs, so the pipeline registers act on them at the next clock edge. Only the trap-PC value is held in a register. The block has no data stream at its edge: every pin is a plain control or address signal with no handshake, and it never back-pressures its neighbours.

Top module: `pipe_redirect_ctl`

## Requirements
- R1: With no overflow and no taken branch, flush_if and flush_ex are low, pc_sel is 0 (sequential) and next_pc equals seq_pc; a branch with mem_br_taken low costs nothing.
- R2: A taken branch (mem_br_op and mem_br_taken both high) with no overflow drives flush_if, id_bubble and flush_ex high in the same cycle, sets pc_sel to 1 and next_pc to mem_br_target.
- R3: mem_br_taken with mem_br_op low is ignored: no flush and sequential next_pc.
- R4: id_bubble is high whenever hz_stall is high, and is also high for any redirect; without either it is low.
- R5: An overflow (ex_ovf high) sets pc_sel to 2 and next_pc to the handler vector TRAP_VEC (default 0x4000_0040), with flush_if, id_bubble and flush_ex all high.
- R6: At the clock edge after an overflow cycle, trap_pc holds ex_pc plus 4 as sampled in that cycle.
- R7: ex_wr_kill is high exactly when ex_ovf is high; a taken branch alone leaves it low.
- R8: When a taken branch and an overflow arrive in the same cycle, the overflow redirect wins: pc_sel is 2 and next_pc is TRAP_VEC.
- R9: trap_pc resets to zero and keeps its value on every edge where ex_ovf is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_br_op | input | 1 | Memory-stage instruction is a conditional branch |
| mem_br_taken | input | 1 | Branch condition outcome from the comparator |
| mem_br_target | input | XLEN | Branch target address |
| ex_ovf | input | 1 | Overflow detected on the execute-stage instruction |
| ex_pc | input | XLEN | Address of the execute-stage instruction |
| hz_stall | input | 1 | Stall request from the hazard unit |
| seq_pc | input | XLEN | Sequential next fetch address |
| flush_if | output | 1 | Zero the instruction captured into the fetch/decode register |
| id_bubble | output | 1 | Zero the control bits entering the decode/execute register |
| flush_ex | output | 1 | Zero the control bits of the execute-stage register |
| ex_wr_kill | output | 1 | Block the destination write of the faulting instruction |
| pc_sel | output | 2 | Fetch source: 0 sequential, 1 branch target, 2 handler vector |
| next_pc | output | XLEN | Next fetch address |
| trap_pc | output | XLEN | Address following the last faulting instruction |

## Verification
The checker follows on every cycle the mapping from branch outcome, overflow and stall to the flush strobes and fetch source, the overflow-over-branch priority, the write block on the faulting instruction, and the one-cycle capture and hold of the trap-PC register. Only the bench's scenarios show that a long run of mixed traffic keeps the trap-PC value tied to the most recent fault, that the reset value is zero, and that an untaken branch or a stray outcome bit with no branch leaves the pipeline untouched.

// File: rtl/pipe_redirect_pkg.sv
package pipe_redirect_pkg;
  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_TRAP = 2'd2
  } pc_src_e;
endpackage

// File: rtl/redirect_arb.sv
module redirect_arb
  import pipe_redirect_pkg::*;
(
  input  logic    br_op,
  input  logic    br_taken,
  input  logic    ovf,
  output pc_src_e src,
  output logic    redirect
);
  logic br_hit;
  assign br_hit = br_op & br_taken;

  always_comb begin
    if (ovf)         src = SEL_TRAP;
    else if (br_hit) src = SEL_BR;
    else             src = SEL_SEQ;
  end

  assign redirect = ovf | br_hit;
endmodule

// File: rtl/flush_gen.sv
module flush_gen #(
  parameter int NSTAGE = 3
) (
  input  logic              redirect,
  input  logic              stall,
  output logic [NSTAGE-1:0] kill
);
  // kill[0]: fetch, kill[1]: decode, kill[2]: execute
  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    if (s == 1) begin : g_dec
      assign kill[s] = redirect | stall;
    end else begin : g_oth
      assign kill[s] = redirect;
    end
  end
endmodule

// File: rtl/npc_mux.sv
module npc_mux
  import pipe_redirect_pkg::*;
#(
  parameter int               XLEN     = 32,
  parameter logic [XLEN-1:0]  TRAP_VEC = 32'h4000_0040
) (
  input  pc_src_e          src,
  input  logic [XLEN-1:0]  seq,
  input  logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  npc
);
  always_comb begin
    unique case (src)
      SEL_BR:   npc = target;
      SEL_TRAP: npc = TRAP_VEC;
      default:  npc = seq;
    endcase
  end
endmodule

// File: rtl/trap_pc_reg.sv
module trap_pc_reg #(
  parameter int XLEN      = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [XLEN-1:0] fault_pc,
  output logic [XLEN-1:0] saved
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved <= '0;
    else if (capture) saved <= fault_pc + STEP;
  end
endmodule

// File: rtl/pipe_redirect_ctl.sv
module pipe_redirect_ctl
  import pipe_redirect_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] TRAP_VEC   = 32'h4000_0040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_br_op,
  input  logic            mem_br_taken,
  input  logic [XLEN-1:0] mem_br_target,
  input  logic            ex_ovf,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            hz_stall,
  input  logic [XLEN-1:0] seq_pc,
  output logic            flush_if,
  output logic            id_bubble,
  output logic            flush_ex,
  output logic            ex_wr_kill,
  output logic [1:0]      pc_sel,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] trap_pc
);
  localparam int NSTAGE = 3;

  pc_src_e           src;
  logic              redirect;
  logic [NSTAGE-1:0] kill;

  redirect_arb u_arb (
    .br_op    (mem_br_op),
    .br_taken (mem_br_taken),
    .ovf      (ex_ovf),
    .src      (src),
    .redirect (redirect)
  );

  flush_gen #(.NSTAGE(NSTAGE)) u_flush (
    .redirect (redirect),
    .stall    (hz_stall),
    .kill     (kill)
  );

  npc_mux #(.XLEN(XLEN), .TRAP_VEC(TRAP_VEC)) u_npc (
    .src    (src),
    .seq    (seq_pc),
    .target (mem_br_target),
    .npc    (next_pc)
  );

  trap_pc_reg #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_tpc (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (ex_ovf),
    .fault_pc (ex_pc),
    .saved    (trap_pc)
  );

  assign flush_if   = kill[0];
  assign id_bubble  = kill[1];
  assign flush_ex   = kill[2];
  assign ex_wr_kill = ex_ovf;
  assign pc_sel     = src;
endmodule

// File: rtl/pipe_redirect_chk.sv
module pipe_redirect_chk #(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] TRAP_VEC   = 32'h4000_0040
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_br_op,
  input logic            mem_br_taken,
  input logic [XLEN-1:0] mem_br_target,
  input logic            ex_ovf,
  input logic [XLEN-1:0] ex_pc,
  input logic            hz_stall,
  input logic [XLEN-1:0] seq_pc,
  input logic            flush_if,
  input logic            id_bubble,
  input logic            flush_ex,
  input logic            ex_wr_kill,
  input logic [1:0]      pc_sel,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] trap_pc
);
  logic br_hit;
  assign br_hit = mem_br_op & mem_br_taken;

  AST_QUIET_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_ovf && !br_hit) |-> (!flush_if && !flush_ex && pc_sel == 2'd0 && next_pc == seq_pc)); // R1
  AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (br_hit && !ex_ovf) |-> (flush_if && id_bubble && flush_ex && pc_sel == 2'd1 && next_pc == mem_br_target)); // R2
  AST_STRAY_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_br_op && !ex_ovf) |-> (!flush_if && !flush_ex)); // R3
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    hz_stall |-> id_bubble); // R4
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |-> (next_pc == TRAP_VEC && flush_if && id_bubble && flush_ex)); // R5
  AST_TRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |=> (trap_pc == $past(ex_pc) + XLEN'(INSN_BYTES))); // R6
  AST_WRITE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wr_kill == ex_ovf); // R7
  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ovf && br_hit) |-> (pc_sel == 2'd2)); // R8
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_ovf |=> $stable(trap_pc)); // R9
endmodule

bind pipe_redirect_ctl pipe_redirect_chk #(
  .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .TRAP_VEC(TRAP_VEC)
) u_chk (.*);

// File: tb/pipe_redirect_ctl_tb.sv
module pipe_redirect_ctl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          XLEN = 32;
  localparam logic [31:0] VEC  = 32'h4000_0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_br_op = 0, mem_br_taken = 0, ex_ovf = 0, hz_stall = 0;
  logic [XLEN-1:0] mem_br_target = '0, ex_pc = '0, seq_pc = '0;
  logic flush_if, id_bubble, flush_ex, ex_wr_kill;
  logic [1:0] pc_sel;
  logic [XLEN-1:0] next_pc, trap_pc;

  int checks = 0;
  int errors = 0;
  logic [XLEN-1:0] model_tpc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_redirect_ctl u_dut (.*);

  function automatic logic [1:0] exp_sel(logic op, logic tk, logic ov);
    if (ov) return 2'd2;
    if (op && tk) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [XLEN-1:0] exp_npc(logic [1:0] s, logic [XLEN-1:0] sq, logic [XLEN-1:0] tg);
    if (s == 2'd2) return VEC;
    if (s == 2'd1) return tg;
    return sq;
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle, check at the falling edge, then advance the trap model.
  task automatic step(string req, logic op, logic tk, logic ov, logic st,
                      logic [XLEN-1:0] tg, logic [XLEN-1:0] pc, logic [XLEN-1:0] sq);
    logic [1:0] s;
    logic redir;
    mem_br_op = op; mem_br_taken = tk; ex_ovf = ov; hz_stall = st;
    mem_br_target = tg; ex_pc = pc; seq_pc = sq;
    @(negedge clk);
    s = exp_sel(op, tk, ov);
    redir = (s != 2'd0);
    chk({req, " pc_sel"},    XLEN'(pc_sel),    XLEN'(s));
    chk({req, " next_pc"},   next_pc,          exp_npc(s, sq, tg));
    chk({req, " flush_if"},  XLEN'(flush_if),  XLEN'(redir));
    chk({req, " id_bubble"}, XLEN'(id_bubble), XLEN'(redir | st));
    chk({req, " flush_ex"},  XLEN'(flush_ex),  XLEN'(redir));
    chk({req, " wr_kill"},   XLEN'(ex_wr_kill), XLEN'(ov));
    chk({req, " trap_pc"},   trap_pc,          model_tpc);
    @(posedge clk);
    #1;
    if (ov) model_tpc = pc + 32'd4;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (2) @(posedge clk);
    #1;
    chk("R9 reset trap_pc", trap_pc, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    step("R1 idle",           0, 0, 0, 0, 32'h100, 32'h10, 32'h44);
    step("R1 branch untaken", 1, 0, 0, 0, 32'h200, 32'h14, 32'h48);
    step("R3 stray outcome",  0, 1, 0, 0, 32'h300, 32'h18, 32'h4c);
    step("R4 stall only",     0, 0, 0, 1, 32'h0,   32'h1c, 32'h50);
    step("R2 taken branch",   1, 1, 0, 0, 32'h72,  32'h20, 32'h54);
    step("R2 taken w/ stall", 1, 1, 0, 1, 32'h88,  32'h24, 32'h58);
    step("R5 R7 overflow",    0, 0, 1, 0, 32'h0,   32'h4c, 32'h54);
    step("R6 capture",        0, 0, 0, 0, 32'h0,   32'h60, 32'h64);
    step("R8 trap beats br",  1, 1, 1, 0, 32'h900, 32'h80, 32'h84);
    step("R6 R9 hold",        0, 0, 0, 1, 32'h0,   32'h90, 32'h94);
    step("R5 ovf max pc",     0, 0, 1, 0, 32'h0,   32'hffff_fffc, 32'h0);
    step("R6 wrap",           0, 0, 0, 0, 32'h0,   32'h0, 32'h4);

    for (int i = 0; i < 400; i++) begin
      logic op, tk, ov, st;
      op = 1'($urandom());
      tk = 1'($urandom());
      ov = (($urandom() % 6) == 0);
      st = (($urandom() % 4) == 0);
      step("R1-mix R2 R4 R5 R6 R7 R8 R9 random", op, tk, ov, st,
           $urandom() & 32'hffff_fffc, $urandom() & 32'hffff_fffc, $urandom() & 32'hffff_fffc);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule